// File: doc/BRIEF.md
# Quadrature x4 Position Counter with Gated Index

This block turns a pair of clean quadrature phase signals and an index signal into a signed-sense position count. Every edge of either phase moves the count by one, so one full cycle of the two phases gives four counts. The count stays between zero and a programmable ceiling. Stepping up past the ceiling wraps it to zero, and stepping down from zero wraps it to the ceiling.

An optional index reset clears the count on a rising index edge. The reset happens only while the two phases sit at a chosen level pair. A swap control exchanges the two phases, which reverses the counting sense.

The block keeps a set of sticky event flags:
- a watchdog timeout when no valid edge arrives in time;
- a reset or wrap while moving up;
- a reset or wrap while moving down;
- a direction change;
- an illegal double-phase transition.

Each flag can be masked off from a single interrupt line. Configuration is taken into internal shadow copies only while counting is disabled.

Top module: `qdec_pos_counter`

## Requirements
- R1: With the logical phase pair {A,B} stepping 00→01→11→10→00, each step adds one to `count` on the clock edge that samples it. `dir_up` reads 1 after such a step.
- R2: The reverse sequence subtracts one per step, and `dir_up` reads 0 afterwards.
- R3: An up step taken while `count` is at or above the ceiling loads 0 and sets status bit 2. A down step taken at 0 loads the ceiling and sets status bit 1.
- R4: A cycle in which both logical phases change leaves `count` unchanged and sets status bit 4.
- R5: When swap is 1, phase input `pha` acts as logical B and `phb` acts as logical A, so the physical up sequence counts down.
- R6: The index reset applies when index reset mode is 1, `idx` has a rising edge, and the logical {A,B} equals the gate field. The gate is read as bit 1 = required A level and bit 0 = required B level.
  - The reset clears `count` to 0 and takes priority over a step in the same cycle.
  - It sets status bit 2 if the last direction was up, or status bit 1 otherwise.
  - The index is ignored on a gate mismatch or when the mode is 0.
- R7: A valid step whose direction differs from the previous direction sets status bit 3.
- R8: With a nonzero watchdog limit L, status bit 0 is set after L consecutive enabled cycles without a valid step. A limit of 0 never sets it.
- R9: Status bits are sticky. A 1 on a `status_clr` bit clears that bit, and an event in the same cycle wins over the clear.
- R10: `irq` is high when any status bit is set whose `irq_mask` bit is 0.
- R11: While `enable` is 0, `count` holds and phase changes are not counted. Configuration inputs are taken only while `enable` is 0, and changes made while enabled are ignored.
- R12: After reset, `count` is 0, `status` is 0, `irq` is 0 and `dir_up` is 1. The shadow ceiling resets to all ones, and the watchdog limit and other modes reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Counting enable; configuration loads while low |
| swap_ab | input | 1 | Exchange the phase roles |
| idx_reset_mode | input | 1 | 1: index clears count |
| idx_gate | input | 2 | Required {A,B} levels for the index |
| ceiling | input | CNT_W | Highest count value |
| wdt_limit | input | WDT_W | Idle cycles to a watchdog event, 0 disables |
| irq_mask | input | STW | 1 blocks the matching status bit from irq |
| status_clr | input | STW | Write-one-to-clear pulses per status bit |
| pha | input | 1 | Phase A input |
| phb | input | 1 | Phase B input |
| idx | input | 1 | Index input |
| count | output | CNT_W | Position count |
| dir_up | output | 1 | Last valid step direction, 1 = up |
| status | output | STW | Sticky event flags |
| irq | output | 1 | Masked interrupt |

## Verification
The bench sweeps small ceilings in both directions, checking every step against an arithmetic model. A design with an off-by-one wrap would land on ceiling+1 or skip zero. The index test tries every gate code against every phase position, where a swapped gate bit order would clear at the wrong position. The swap, illegal double transition and disabled-counting cases each check the count stays or reverses exactly. The watchdog is checked one cycle before and at its limit, so an early or late timeout is caught.

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter #(
  parameter int CNT_W = 32,
  parameter int WDT_W = 16,
  parameter int STW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             swap_ab,
  input  logic             idx_reset_mode,
  input  logic [1:0]       idx_gate,
  input  logic [CNT_W-1:0] ceiling,
  input  logic [WDT_W-1:0] wdt_limit,
  input  logic [STW-1:0]   irq_mask,
  input  logic [STW-1:0]   status_clr,
  input  logic             pha,
  input  logic             phb,
  input  logic             idx,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic [STW-1:0]   status,
  output logic             irq
);

  logic             swap_q, mode_q;
  logic [1:0]       gate_q;
  logic [CNT_W-1:0] ceil_q;
  logic [WDT_W-1:0] wlim_q, wcnt;
  logic [1:0]       ab_q;
  logic             idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_q <= 1'b0;
      mode_q <= 1'b0;
      gate_q <= '0;
      ceil_q <= '1;
      wlim_q <= '0;
    end else if (!enable) begin
      swap_q <= swap_ab;
      mode_q <= idx_reset_mode;
      gate_q <= idx_gate;
      ceil_q <= ceiling;
      wlim_q <= wdt_limit;
    end
  end

  wire       a_in  = swap_q ? phb : pha;
  wire       b_in  = swap_q ? pha : phb;
  wire [1:0] p_old = {ab_q[1], ab_q[1] ^ ab_q[0]};
  wire [1:0] p_new = {a_in, a_in ^ b_in};
  wire [1:0] diff  = p_new - p_old;

  wire step_up = enable && (diff == 2'd1);
  wire step_dn = enable && (diff == 2'd3);
  wire bad     = enable && (diff == 2'd2);
  wire step    = step_up || step_dn;
  wire idx_hit = enable && mode_q && idx && !idx_q && ({a_in, b_in} == gate_q);
  wire wrap_up = step_up && (count >= ceil_q);
  wire wrap_dn = step_dn && (count == '0);
  wire wdt_hit = enable && !step && (wlim_q != '0) && (wcnt != wlim_q) &&
                 ((wcnt + WDT_W'(1)) == wlim_q);

  logic [STW-1:0] ev;
  always_comb begin
    ev    = '0;
    ev[0] = wdt_hit;
    ev[1] = idx_hit ? !dir_up : wrap_dn;
    ev[2] = idx_hit ?  dir_up : wrap_up;
    ev[3] = (step_up && !dir_up) || (step_dn && dir_up);
    ev[4] = bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q   <= '0;
      idx_q  <= 1'b0;
      count  <= '0;
      dir_up <= 1'b1;
      status <= '0;
      wcnt   <= '0;
    end else begin
      ab_q   <= {a_in, b_in};
      idx_q  <= idx;
      status <= (status & ~status_clr) | ev;
      if (step) dir_up <= step_up;
      if (idx_hit)      count <= '0;
      else if (step_up) count <= wrap_up ? '0 : count + CNT_W'(1);
      else if (step_dn) count <= wrap_dn ? ceil_q : count - CNT_W'(1);
      if (!enable || step) wcnt <= '0;
      else if ((wlim_q != '0) && (wcnt != wlim_q)) wcnt <= wcnt + WDT_W'(1);
    end
  end

  assign irq = |(status & ~irq_mask);

  // R11
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(count));

  // R4
  bad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad && !idx_hit |=> $stable(count) && status[4]);

  // R3
  wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn && !idx_hit && (count == '0) |=> count == ceil_q);

  // R6
  index_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_hit |=> count == '0);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && (status_clr == '0) |=> status == $past(status));

  // R10
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_mask) |-> !irq);

endmodule

// File: tb/qdec_pos_counter_tb.sv
`timescale 1ns/1ps
module qdec_pos_counter_tb;
  logic        clk = 0, rst_n = 0, enable = 0, swap_ab = 0, idx_reset_mode = 0;
  logic [1:0]  idx_gate = 0;
  logic [31:0] ceiling = '1;
  logic [15:0] wdt_limit = 0;
  logic [4:0]  irq_mask = '1, status_clr = 0;
  logic        pha = 0, phb = 0, idx = 0;
  logic [31:0] count;
  logic        dir_up, irq;
  logic [4:0]  status;

  int n_chk = 0, n_fail = 0;
  logic [1:0]  pp = 0;
  logic [31:0] exp_cnt = 0, exp_ceil = '1;
  bit          exp_dir = 1, sw = 0, en_b = 0;

  always #2 clk = ~clk;

  qdec_pos_counter u_dut (.clk(clk), .rst_n(rst_n), .enable(enable), .swap_ab(swap_ab),
    .idx_reset_mode(idx_reset_mode), .idx_gate(idx_gate), .ceiling(ceiling),
    .wdt_limit(wdt_limit), .irq_mask(irq_mask), .status_clr(status_clr),
    .pha(pha), .phb(phb), .idx(idx), .count(count), .dir_up(dir_up),
    .status(status), .irq(irq));

  function automatic logic [1:0] gray(input logic [1:0] p);
    return {p[1], p[1] ^ p[0]};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic set_cfg(input bit s, input bit m, input logic [1:0] g,
                         input logic [31:0] c, input logic [15:0] w);
    @(negedge clk);
    enable = 0; swap_ab = s; idx_reset_mode = m; idx_gate = g; ceiling = c; wdt_limit = w;
    repeat (2) @(posedge clk);
    @(negedge clk);
    enable = 1; sw = s; exp_ceil = c; en_b = 1;
    @(posedge clk); #1;
  endtask

  task automatic pstep(input bit fwd);
    bit up;
    @(negedge clk);
    pp = fwd ? pp + 2'd1 : pp - 2'd1;
    {pha, phb} = gray(pp);
    if (en_b) begin
      up = fwd ^ sw;
      if (up) exp_cnt = (exp_cnt >= exp_ceil) ? 0 : exp_cnt + 1;
      else    exp_cnt = (exp_cnt == 0) ? exp_ceil : exp_cnt - 1;
      exp_dir = up;
    end
    @(posedge clk); #1;
  endtask

  task automatic clr_all;
    @(negedge clk); status_clr = '1;
    @(posedge clk); #1; status_clr = '0;
  endtask

  task automatic idx_pulse;
    @(negedge clk); idx = 1;
    @(posedge clk); #1; idx = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (20) @(posedge clk); #1;
    chk("R12 count", count, 0);
    chk("R12 status", 32'(status), 0);
    chk("R12 irq", 32'(irq), 0);
    chk("R12 dir", 32'(dir_up), 1);
    chk("R8 limit zero no timeout", 32'(status[0]), 0);

    for (int c = 0; c <= 4; c++) begin
      set_cfg(0, 0, 0, c, 0);
      clr_all;
      for (int i = 0; i < 2*c + 5; i++) begin
        pstep(1);
        chk("R1 up count", count, exp_cnt);
        chk("R1 dir up", 32'(dir_up), 1);
      end
      chk("R3 up wrap flag", 32'(status[2]), 1);
      clr_all;
      pstep(0);
      chk("R7 dir change flag", 32'(status[3]), 1);
      chk("R2 down count", count, exp_cnt);
      for (int i = 0; i < 2*c + 4; i++) begin
        pstep(0);
        chk("R2 down count", count, exp_cnt);
        chk("R2 dir down", 32'(dir_up), 0);
      end
      chk("R3 down wrap flag", 32'(status[1]), 1);
    end

    set_cfg(0, 0, 0, 99, 0);
    clr_all;
    @(negedge clk); pp = pp + 2'd2; {pha, phb} = gray(pp);
    @(posedge clk); #1;
    chk("R4 count held", count, exp_cnt);
    chk("R4 error flag", 32'(status[4]), 1);

    set_cfg(1, 0, 0, 99, 0);
    for (int i = 0; i < 6; i++) begin
      pstep(1);
      chk("R5 swapped sense", count, exp_cnt);
      chk("R5 swapped dir", 32'(dir_up), 0);
    end

    for (int g = 0; g < 4; g++) begin
      set_cfg(0, 1, 2'(g), 99, 0);
      for (int p = 0; p < 4; p++) begin
        bit hit;
        repeat (4) pstep(1);
        while (pp != 2'(p)) pstep(1);
        clr_all;
        hit = (gray(pp) == 2'(g));
        idx_pulse;
        if (hit) exp_cnt = 0;
        chk("R6 gated index count", count, exp_cnt);
        chk("R6 up reset flag", 32'(status[2]), 32'(hit));
        @(posedge clk); #1;
      end
    end
    pstep(1); pstep(0);
    clr_all;
    idx_gate = gray(pp);
    set_cfg(0, 1, gray(pp), 99, 0);
    idx_pulse; exp_cnt = 0;
    chk("R6 down reset flag", 32'(status[1]), 1);
    @(posedge clk); #1;
    pstep(1); pstep(1);
    set_cfg(0, 0, gray(pp), 99, 0);
    idx_pulse;
    chk("R6 mode zero ignores index", count, exp_cnt);

    set_cfg(0, 0, 0, 9, 0);
    @(negedge clk); enable = 0; en_b = 0;
    repeat (3) pstep(1);
    chk("R11 disabled holds", count, exp_cnt);
    @(negedge clk); enable = 1; en_b = 1;
    @(posedge clk); #1;
    chk("R11 no step on re-enable", count, exp_cnt);
    while (exp_cnt != 3) pstep(1);
    @(negedge clk); ceiling = 2;
    pstep(1);
    chk("R11 ceiling change ignored while enabled", count, 4);

    set_cfg(0, 0, 0, 9, 6);
    pstep(1);
    clr_all;
    repeat (4) @(posedge clk); #1;
    chk("R8 no timeout before limit", 32'(status[0]), 0);
    @(posedge clk); #1;
    chk("R8 timeout at limit", 32'(status[0]), 1);
    chk("R9 other bits clear", 32'(status[4:1]), 0);

    @(negedge clk); irq_mask = 5'b11111; #1;
    chk("R10 all masked", 32'(irq), 0);
    @(negedge clk); irq_mask = 5'b11110; #1;
    chk("R10 bit0 unmasked", 32'(irq), 1);
    @(negedge clk); irq_mask = 5'b00001; #1;
    chk("R10 only clear bits unmasked", 32'(irq), 0);
    @(negedge clk); status_clr = 5'b00010;
    @(posedge clk); #1; status_clr = 0;
    chk("R9 clear of other bit keeps bit0", 32'(status[0]), 1);
    @(negedge clk); status_clr = 5'b00001;
    @(posedge clk); #1; status_clr = 0;
    chk("R9 write one clears", 32'(status[0]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule